// File: doc/BRIEF.md
# Twelve-Pin Configurable GPIO Port

This block controls twelve bidirectional general-purpose pads through a small byte-wide register window. Each pin has its own direction bit, read-inversion bit and output-value bit. Groups of four pins share an output-type choice, either push-pull or open-drain. One mode bit decides whether a new output pattern reaches all pads in the same clock or ripples across them one pin per clock, which limits the switching current drawn at once.

Reads of the two pin-value bytes always sample the pad itself. The pad level is passed through the per-pin inversion mask, so an output pin that an outside source holds low reads as low, whatever the output register holds. All writable state is loaded from a set of default-value inputs while reset is held and again whenever a refresh pulse arrives. Register writes take effect at the clock edge that samples them. Reads are combinational from the read address.

Register window, by offset: 0 = direction of pins 7:0; 1 = direction of pins 11:8 in bits 3:0; 2 = inversion of pins 7:0; 3 = shared configuration byte; 4 = output value of pins 7:0; 5 = output value of pins 11:8 in bits 3:0; 6 = pin value of pins 7:0; 7 = pin value of pins 11:8 in bits 3:0. Pin n always sits at bit n mod 8 of its byte.

Top module: `gpio12_port`

## Requirements
- R1: A direction bit of 1 makes the pin an input and forces its `pad_oe` to 0. A direction bit of 0 makes it an output.
- R2: Pin-value bit n reads `pad_in[n]` XOR inversion bit n. Pins 7:0 are at offset 6 and pins 11:8 at offset 7, bits 3:0.
- R3: Pin-value reads work for pins of either direction and report the pad level, even where that level differs from the output register.
- R4: Bits 7:4 at offsets 7, 1 and 5 always read 0. Writes to those bits are dropped.
- R5: Writes to offsets 6 and 7 have no effect on any register or pad output.
- R6: Offset 3 holds inversion bits of pins 11:8 in bits 3:0. Bits 4, 5 and 6 select open-drain (1) or push-pull (0) for pins 3:0, 7:4 and 11:8. An open-drain output pin drives 0 with `pad_oe`=1 when its value is 0 and releases (`pad_oe`=0) when it is 1. A push-pull output pin drives its value with `pad_oe`=1.
- R7: While `rst_n` is low, and at an edge where `refresh` is 1, every register loads from the default inputs and the pad drive value loads from `dflt_out`. Refresh takes priority over a write in the same cycle.
- R8: With bit 7 of offset 3 at 0 (simultaneous mode), the pads show the output register one clock after it changes, all pins in the same cycle.
- R9: With bit 7 of offset 3 at 1 (sequential mode), any register write starts a sweep. Pin k takes its new output value k+1 clocks after the write edge, at most one pin changing per clock. With no sweep running, the drive value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads defaults |
| refresh | input | 1 | Reload all registers from the default inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read data, combinational |
| dflt_dir | input | 12 | Default direction bits |
| dflt_inv | input | 12 | Default inversion bits |
| dflt_out | input | 12 | Default output values |
| dflt_otype | input | 3 | Default output type per group of four |
| dflt_mode | input | 1 | Default switching mode |
| pad_in | input | 12 | Pad levels |
| pad_oe | output | 12 | Pad output enables |
| pad_do | output | 12 | Pad output data |

## Verification
The cycle properties cover the invariants: an input pin never drives, an open-drain pin never drives high, the upper pin-value nibble reads zero, the low pin-value byte tracks the pad through the mask, and simultaneous mode follows the register with one clock of delay. They also cover a sequential sweep moving at most one pin per clock and holding when idle, and refresh loading the defaults. The bench alone shows the exact clock on which each pin changes during a sweep, and that readback reports a level held by an outside source rather than the register value. It alone shows that writes to read-only or reserved bits leave every register untouched, and it sweeps the full set of pin-value and inversion combinations.

// File: rtl/gpio12_pkg.sv
package gpio12_pkg;
  localparam int unsigned PIN_COUNT = 12;
  localparam int unsigned GRP_SIZE  = 4;
  localparam int unsigned ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR_LO  = 3'd0,
    A_DIR_HI  = 3'd1,
    A_INV_LO  = 3'd2,
    A_INV_CFG = 3'd3,
    A_OUT_LO  = 3'd4,
    A_OUT_HI  = 3'd5,
    A_PIN_LO  = 3'd6,
    A_PIN_HI  = 3'd7
  } reg_addr_e;

  // enable for one pad: inputs never drive, open-drain releases on a 1
  function automatic logic pad_oe_f(input logic is_in, input logic od, input logic val);
    return !is_in && (!od || !val);
  endfunction

  // data for one pad: open-drain only ever drives 0
  function automatic logic pad_do_f(input logic od, input logic val);
    return val && !od;
  endfunction

  // value seen by a read of a pin
  function automatic logic pin_read_f(input logic lvl, input logic inv);
    return lvl ^ inv;
  endfunction
endpackage

// File: rtl/gpio12_regs.sv
module gpio12_regs
  import gpio12_pkg::*;
#(
  parameter int unsigned NPINS = PIN_COUNT,
  parameter int unsigned NGRP  = PIN_COUNT / GRP_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NPINS-1:0]  dflt_dir,
  input  logic [NPINS-1:0]  dflt_inv,
  input  logic [NPINS-1:0]  dflt_out,
  input  logic [NGRP-1:0]   dflt_otype,
  input  logic              dflt_mode,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  inv_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NGRP-1:0]   otype_q,
  output logic              mode_q,
  output logic [7:0]        rd_data
);
  localparam int unsigned HI  = NPINS - 8;
  localparam int unsigned PAD = 8 - HI;

  reg_addr_e wa, ra;
  logic [NPINS-1:0] pin_val;

  assign wa = reg_addr_e'(wr_addr);
  assign ra = reg_addr_e'(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= dflt_dir;
      inv_q   <= dflt_inv;
      out_q   <= dflt_out;
      otype_q <= dflt_otype;
      mode_q  <= dflt_mode;
    end else if (refresh) begin
      dir_q   <= dflt_dir;
      inv_q   <= dflt_inv;
      out_q   <= dflt_out;
      otype_q <= dflt_otype;
      mode_q  <= dflt_mode;
    end else if (wr_en) begin
      case (wa)
        A_DIR_LO:  dir_q[7:0]       <= wr_data;
        A_DIR_HI:  dir_q[NPINS-1:8] <= wr_data[HI-1:0];
        A_INV_LO:  inv_q[7:0]       <= wr_data;
        A_INV_CFG: begin
          inv_q[NPINS-1:8] <= wr_data[HI-1:0];
          otype_q          <= wr_data[HI+NGRP-1:HI];
          mode_q           <= wr_data[7];
        end
        A_OUT_LO:  out_q[7:0]       <= wr_data;
        A_OUT_HI:  out_q[NPINS-1:8] <= wr_data[HI-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++) pin_val[p] = pin_read_f(pad_in[p], inv_q[p]);
  end

  always_comb begin
    case (ra)
      A_DIR_LO:  rd_data = dir_q[7:0];
      A_DIR_HI:  rd_data = {{PAD{1'b0}}, dir_q[NPINS-1:8]};
      A_INV_LO:  rd_data = inv_q[7:0];
      A_INV_CFG: rd_data = {mode_q, otype_q, inv_q[NPINS-1:8]};
      A_OUT_LO:  rd_data = out_q[7:0];
      A_OUT_HI:  rd_data = {{PAD{1'b0}}, out_q[NPINS-1:8]};
      A_PIN_LO:  rd_data = pin_val[7:0];
      default:   rd_data = {{PAD{1'b0}}, pin_val[NPINS-1:8]};
    endcase
  end
endmodule

// File: rtl/gpio12_stage.sv
module gpio12_stage
  import gpio12_pkg::*;
#(
  parameter int unsigned NPINS = PIN_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh,
  input  logic             kick,
  input  logic             seq_mode,
  input  logic [NPINS-1:0] dflt_out,
  input  logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] drv_q,
  output logic             sweep_on
);
  localparam int unsigned PW = $clog2(NPINS);
  localparam logic [PW-1:0] LAST = PW'(NPINS - 1);

  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q    <= dflt_out;
      sweep_on <= 1'b0;
      ptr      <= '0;
    end else if (refresh) begin
      drv_q    <= dflt_out;
      sweep_on <= 1'b0;
      ptr      <= '0;
    end else begin
      if (!seq_mode)     drv_q      <= out_q;
      else if (sweep_on) drv_q[ptr] <= out_q[ptr];
      if (kick) begin
        sweep_on <= 1'b1;
        ptr      <= '0;
      end else if (sweep_on) begin
        if (ptr == LAST) sweep_on <= 1'b0;
        else             ptr      <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio12_padctl.sv
module gpio12_padctl
  import gpio12_pkg::*;
#(
  parameter int unsigned GW = GRP_SIZE
) (
  input  logic [GW-1:0] is_in,
  input  logic          od,
  input  logic [GW-1:0] val,
  output logic [GW-1:0] oe,
  output logic [GW-1:0] dout
);
  always_comb begin
    for (int i = 0; i < GW; i++) begin
      oe[i]   = pad_oe_f(is_in[i], od, val[i]);
      dout[i] = pad_do_f(od, val[i]);
    end
  end
endmodule

// File: rtl/gpio12_port.sv
module gpio12_port
  import gpio12_pkg::*;
#(
  parameter int unsigned NPINS = PIN_COUNT,
  parameter int unsigned GW    = GRP_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [NPINS-1:0]  dflt_dir,
  input  logic [NPINS-1:0]  dflt_inv,
  input  logic [NPINS-1:0]  dflt_out,
  input  logic [NPINS/GW-1:0] dflt_otype,
  input  logic              dflt_mode,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_do
);
  localparam int unsigned NGRP = NPINS / GW;

  logic [NPINS-1:0] dir_w, inv_w, out_w, drv_w;
  logic [NGRP-1:0]  otype_w;
  logic             mode_w, sweep_w;

  gpio12_regs #(.NPINS(NPINS), .NGRP(NGRP)) regs_i (
    .clk(clk), .rst_n(rst_n), .refresh(refresh),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .dflt_dir(dflt_dir), .dflt_inv(dflt_inv), .dflt_out(dflt_out),
    .dflt_otype(dflt_otype), .dflt_mode(dflt_mode), .pad_in(pad_in),
    .dir_q(dir_w), .inv_q(inv_w), .out_q(out_w), .otype_q(otype_w),
    .mode_q(mode_w), .rd_data(rd_data)
  );

  gpio12_stage #(.NPINS(NPINS)) stage_i (
    .clk(clk), .rst_n(rst_n), .refresh(refresh), .kick(wr_en),
    .seq_mode(mode_w), .dflt_out(dflt_out), .out_q(out_w),
    .drv_q(drv_w), .sweep_on(sweep_w)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio12_padctl #(.GW(GW)) pad_i (
      .is_in(dir_w[g*GW +: GW]), .od(otype_w[g]), .val(drv_w[g*GW +: GW]),
      .oe(pad_oe[g*GW +: GW]), .dout(pad_do[g*GW +: GW])
    );
  end
endmodule

// File: rtl/gpio12_port_chk.sv
module gpio12_port_chk #(
  parameter int unsigned NPINS = 12,
  parameter int unsigned GW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh,
  input logic             wr_en,
  input logic [2:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] dflt_dir,
  input logic [NPINS-1:0] dir_w,
  input logic [NPINS-1:0] inv_w,
  input logic [NPINS-1:0] out_w,
  input logic [NPINS-1:0] drv_w,
  input logic [NPINS/GW-1:0] otype_w,
  input logic             mode_w,
  input logic             sweep_w
);
  logic [NPINS-1:0] od_mask;
  logic [NPINS-1:0] rd_expect;

  always_comb begin
    for (int p = 0; p < NPINS; p++) od_mask[p] = otype_w[p / GW];
    rd_expect = pad_in ^ inv_w;
  end

  assert_input_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_w) == '0);

  assert_pin_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd6) |-> (rd_data == rd_expect[7:0]));

  assert_hi_nibble_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd7) |-> (rd_data[7:4] == 4'd0));

  assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_do & od_mask) == '0);

  assert_refresh_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (dir_w == $past(dflt_dir)));

  assert_simul_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_w && !refresh) |=> (drv_w == $past(out_w)));

  assert_seq_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w && !refresh) |=> $onehot0(drv_w ^ $past(drv_w)));

  assert_seq_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w && !sweep_w && !wr_en && !refresh) |=> $stable(drv_w));
endmodule

bind gpio12_port gpio12_port_chk #(.NPINS(NPINS), .GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .refresh(refresh), .wr_en(wr_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_do(pad_do), .dflt_dir(dflt_dir), .dir_w(dir_w), .inv_w(inv_w),
  .out_w(out_w), .drv_w(drv_w), .otype_w(otype_w), .mode_w(mode_w),
  .sweep_w(sweep_w)
);

// File: tb/gpio12_port_tb_top.sv
module gpio12_port_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, refresh = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic [11:0] pad_in, pad_oe, pad_do, ext_lvl = 12'h000;
  localparam logic [11:0] D_DIR = 12'hFFF, D_INV = 12'h3C5, D_OUT = 12'h9A6;
  localparam logic [2:0]  D_OT = 3'b000;
  localparam logic        D_MD = 1'b0;

  // pads driven by the block when enabled, by the outside otherwise
  assign pad_in = (pad_oe & pad_do) | (~pad_oe & ext_lvl);

  gpio12_port dut_i (
    .clk(clk), .rst_n(rst_n), .refresh(refresh), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dflt_dir(D_DIR), .dflt_inv(D_INV), .dflt_out(D_OUT), .dflt_otype(D_OT),
    .dflt_mode(D_MD), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [11:0] m_dir, m_inv, m_out;
  logic [2:0]  m_ot;
  logic        m_md;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    m_dir = D_DIR; m_inv = D_INV; m_out = D_OUT; m_ot = D_OT; m_md = D_MD;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_dir[7:0]  = d;
      3'd1: m_dir[11:8] = d[3:0];
      3'd2: m_inv[7:0]  = d;
      3'd3: begin m_inv[11:8] = d[3:0]; m_ot = d[6:4]; m_md = d[7]; end
      3'd4: m_out[7:0]  = d;
      3'd5: m_out[11:8] = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [7:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return m_dir[7:0];
      3'd1: return {4'h0, m_dir[11:8]};
      3'd2: return m_inv[7:0];
      3'd3: return {m_md, m_ot, m_inv[11:8]};
      3'd4: return m_out[7:0];
      default: return {4'h0, m_out[11:8]};
    endcase
  endfunction

  function automatic logic [11:0] exp_oe(input logic [11:0] val);
    logic [11:0] r;
    for (int p = 0; p < 12; p++) r[p] = !m_dir[p] && !(m_ot[p/4] && val[p]);
    return r;
  endfunction

  function automatic logic [11:0] exp_do(input logic [11:0] val);
    logic [11:0] r;
    for (int p = 0; p < 12; p++) r[p] = val[p] && !m_ot[p/4];
    return r;
  endfunction

  function automatic logic [11:0] exp_lvl(input logic [11:0] val);
    logic [11:0] oe, dd;
    oe = exp_oe(val); dd = exp_do(val);
    return (oe & dd) | (~oe & ext_lvl);
  endfunction

  task automatic check_regs(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check(tag, {24'd0, v}, {24'd0, exp_reg(3'(a))});
    end
  endtask

  task automatic check_pins(input string tag);
    logic [7:0] lo, hi;
    logic [11:0] e;
    e = exp_lvl(m_out) ^ m_inv;
    rd(3'd6, lo); rd(3'd7, hi);
    check(tag, {24'd0, lo}, {24'd0, e[7:0]});
    check(tag, {24'd0, hi}, {28'd0, e[11:8]});
  endtask

  task automatic check_pads(input string tag, input logic [11:0] val);
    check(tag, {20'd0, pad_oe}, {20'd0, exp_oe(val)});
    check(tag, {20'd0, pad_do}, {20'd0, exp_do(val)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    logic [11:0] old_v, new_v, e;
    model_defaults();
    repeat (3) @(negedge clk);
    // R7: defaults visible while reset is held and after release
    check_regs("R7 reset defaults");
    check_pads("R1 R7 reset pads", D_OUT);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_regs("R7 after release");

    // R2 R4: exhaustive pin-value sweep, all pins input, two masks
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin wr(3'd2, 8'h69); wr(3'd3, 8'h0B); end
      for (int v = 0; v < 4096; v++) begin
        ext_lvl = 12'(v);
        rd(3'd6, lo); rd(3'd7, hi);
        e = 12'(v) ^ m_inv;
        check("R2 pin value low byte", {24'd0, lo}, {24'd0, e[7:0]});
        check("R4 R2 pin value high byte", {24'd0, hi}, {28'd0, e[11:8]});
      end
    end

    // R1: direction patterns, push-pull
    ext_lvl = 12'h5A5;
    foreach (m_dir[i]) ; // no-op to keep loop style uniform
    wr(3'd0, 8'hF0); wr(3'd1, 8'h05);
    check_pads("R1 direction F0/5", m_out);
    check_pins("R3 mixed directions");
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    check_pads("R1 all outputs", m_out);
    check_pins("R3 outputs read from pad");

    // R4 R5: reserved bits and read-only offsets
    wr(3'd1, 8'hF3);
    wr(3'd5, 8'hE6);
    check_regs("R4 reserved bits dropped");
    old_v = m_out;
    @(negedge clk);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF); wr(3'd6, 8'h00);
    @(negedge clk);
    check_regs("R5 read-only write ignored");
    check_pads("R5 pads unchanged", old_v);
    check_pins("R5 pin values unchanged");

    // R6: open-drain on groups 0 and 2, outside pulls low
    ext_lvl = 12'h000;
    wr(3'd3, 8'h50 | {4'h0, m_inv[11:8]});
    for (int k = 0; k < 4; k++) begin
      new_v = 12'(k * 12'h3A7 + 12'h0F1);
      wr(3'd4, new_v[7:0]); wr(3'd5, {4'h0, new_v[11:8]});
      @(negedge clk);
      check_pads("R6 open-drain groups", m_out);
      check_pins("R3 released pin reads pad not register");
    end
    wr(3'd3, 8'h20 | {4'h0, m_inv[11:8]});
    @(negedge clk);
    check_pads("R6 open-drain group 1 only", m_out);
    wr(3'd3, {4'h0, m_inv[11:8]});
    @(negedge clk);

    // R8: simultaneous mode, one clock latency, all pins together
    old_v = m_out;
    wr(3'd4, ~m_out[7:0]);
    check("R8 not yet applied", {20'd0, pad_do}, {20'd0, old_v});
    @(negedge clk);
    check("R8 all applied next clock", {20'd0, pad_do}, {20'd0, m_out});

    // R9: sequential mode, pin k changes k+1 clocks after the write
    wr(3'd3, 8'h80 | {4'h0, m_inv[11:8]});
    repeat (14) @(negedge clk);
    for (int run = 0; run < 2; run++) begin
      old_v = m_out;
      if (run == 0) wr(3'd4, ~m_out[7:0]);
      else          wr(3'd5, {4'h0, ~m_out[11:8]});
      new_v = m_out;
      check("R9 sweep not started", {20'd0, pad_do}, {20'd0, old_v});
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        for (int p = 0; p < 12; p++) e[p] = (p <= k) ? new_v[p] : old_v[p];
        check("R9 staggered pin update", {20'd0, pad_do}, {20'd0, e});
      end
      repeat (3) @(negedge clk);
      check("R9 held after sweep", {20'd0, pad_do}, {20'd0, new_v});
    end

    // R7: refresh reloads everything, wins over a same-cycle write
    @(negedge clk);
    refresh = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h3C;
    @(negedge clk);
    refresh = 1'b0; wr_en = 1'b0;
    model_defaults();
    check_regs("R7 refresh reload");
    check_pads("R7 refresh pads", D_OUT);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule